// File: doc/BRIEF.md
# Memory-Mapped Bidirectional GPIO Port

This block is a general-purpose I/O port of configurable width, eight bits by default. A simple register bus reaches three registers: a per-bit direction register, an output latch, and a read-only view of the synchronized pin levels. Because pin levels and latch contents sit at separate addresses, software can read-modify-write the latch without picking up whatever an external device is forcing onto a pin.

On the pin side the block drives per-bit output data and output enables, and it takes raw pin levels through a two-stage synchronizer. Three per-bit controls change how bits behave:

- An analog-select input forces port reads of analog-capable bits to zero.
- A single claim input gives the top bits to the clock oscillator. Those bits then read as zero at every address and are never driven.
- A peripheral override hands a pin's data and enable to another on-chip function.

Top module: `gpio_port`

## Requirements
- R1: A direction bit of 1 makes its pin an input (`pin_oe` bit 0). A direction bit of 0 enables the driver (`pin_oe` bit 1), and `pin_out` for that bit carries the latch bit. A direction write changes `pin_oe` from the clock edge after the write.
- R2: A read of address 0 (pin register) returns the pin levels two clock edges after they change. After only one edge it still returns the old level.
- R3: A write to address 0 or address 1 loads the output latch on the next edge. A read of address 1 returns the latch and not the pin levels.
- R4: A bit with `analog_sel` set reads as 0 on pin-register reads, but only where it is analog-capable (default capable mask 0x2F: bits 5 and 3..0). On other bits `analog_sel` has no effect.
- R5: While `osc_claim` is 1, bits 7..6 read as 0 at addresses 0, 1 and 2, and their `pin_oe` and `pin_out` are 0 regardless of direction, latch or peripheral.
- R6: While `osc_claim` is 1, latch bits 7..6 are held at 0 and writes to them are ignored. After the claim is released they still read 0 until they are written again.
- R7: After a synchronous active-low reset, the direction register is all ones, the latch is zero, the synchronizer holds zero and every `pin_oe` bit is 0.
- R8: With `periph_en` set on an unclaimed bit, `pin_out` and `pin_oe` for that bit follow `periph_out` and `periph_oe` instead of the latch and direction bits.
- R9: Address 2 reads and writes the direction register. Address 3 reads 0 and ignores writes. `bus_rdata` is 0 whenever `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 pins, 1 latch, 2 direction, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | WIDTH | Combinational read data |
| pin_in | input | WIDTH | Raw pin levels |
| pin_out | output | WIDTH | Pin drive data |
| pin_oe | output | WIDTH | Pin driver enable, 1 drives |
| analog_sel | input | WIDTH | Per-bit analog assignment |
| osc_claim | input | 1 | Top bits taken by the oscillator |
| periph_en | input | WIDTH | Per-bit peripheral override enable |
| periph_out | input | WIDTH | Peripheral drive data |
| periph_oe | input | WIDTH | Peripheral driver enable |

## Verification
A corrupted direction or latch bit shows at `pin_oe` or `pin_out` in the same cycle, and it shows on the next read of address 1 or 2. A stuck synchronizer stage shows as a pin-register read that is wrong two edges after a pin change, or as one that arrives an edge early. A claimed latch bit that fails to clear is hidden while the claim lasts. It appears only at the first latch read after the claim is released, so the bench releases the claim and reads the latch straight away.

// File: rtl/gpio_pkg.sv
// Shared definitions for the GPIO port: register address encoding.
// Assumes a two-bit register address on the bus.
package gpio_pkg;
    localparam int GPIO_AW = 2;

    typedef enum logic [GPIO_AW-1:0] {
        REG_PINS  = 2'd0,
        REG_DRIVE = 2'd1,
        REG_DIR   = 2'd2,
        REG_NONE  = 2'd3
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
// Two-stage synchronizer for the raw pin levels.
// Assumes the pins are asynchronous to clk; resets both stages to zero.
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift pin levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_regs.sv
// Direction and output-latch registers of the port.
// Assumes claim_mask marks the bits currently taken by the oscillator;
// those latch bits are cleared and protected from writes.
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_reg_e        wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] claim_mask,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] latch_q
);
    logic latch_hit;
    logic dir_hit;

    // Decode which register a write lands in.
    always_comb begin
        latch_hit = wr_en && (wr_sel == REG_PINS || wr_sel == REG_DRIVE);
        dir_hit   = wr_en && (wr_sel == REG_DIR);
    end

    // Update direction register; reset leaves every pin an input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (dir_hit) begin
            dir_q <= wr_data;
        end
    end

    // Update latch; claimed bits are forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (latch_hit) begin
            latch_q <= wr_data & ~claim_mask;
        end else begin
            latch_q <= latch_q & ~claim_mask;
        end
    end
endmodule

// File: rtl/gpio_pad_ctl.sv
// Per-bit selection of pin drive data and enable.
// Priority per bit: oscillator claim, then peripheral override, then
// the general-purpose direction and latch.
module gpio_pad_ctl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] claim_mask,
    input  logic [WIDTH-1:0] periph_en,
    input  logic [WIDTH-1:0] periph_out,
    input  logic [WIDTH-1:0] periph_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Pick drive source for one pin.
        always_comb begin
            if (claim_mask[i]) begin
                pin_out[i] = 1'b0;
                pin_oe[i]  = 1'b0;
            end else if (periph_en[i]) begin
                pin_out[i] = periph_out[i];
                pin_oe[i]  = periph_oe[i];
            end else begin
                pin_out[i] = latch_q[i];
                pin_oe[i]  = ~dir_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
// Memory-mapped bidirectional GPIO port (top).
// Assumes a single clock domain for the bus; pins are synchronized.
// Read data is combinational and zero when no read is strobed.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int              WIDTH          = 8,
    parameter int              OSC_BITS       = 2,
    parameter logic [WIDTH-1:0] ANALOG_CAPABLE = 8'h2F
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GPIO_AW-1:0]  bus_addr,
    input  logic                bus_wr,
    input  logic [WIDTH-1:0]    bus_wdata,
    input  logic                bus_rd,
    output logic [WIDTH-1:0]    bus_rdata,
    input  logic [WIDTH-1:0]    pin_in,
    output logic [WIDTH-1:0]    pin_out,
    output logic [WIDTH-1:0]    pin_oe,
    input  logic [WIDTH-1:0]    analog_sel,
    input  logic                osc_claim,
    input  logic [WIDTH-1:0]    periph_en,
    input  logic [WIDTH-1:0]    periph_out,
    input  logic [WIDTH-1:0]    periph_oe
);
    localparam logic [WIDTH-1:0] OSC_MASK = ~({WIDTH{1'b1}} >> OSC_BITS);

    logic [WIDTH-1:0] claim_mask;
    logic [WIDTH-1:0] analog_mask;
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] latch_q;
    gpio_reg_e        sel;

    // Derive per-bit masks from the configuration inputs.
    always_comb begin
        claim_mask  = osc_claim ? OSC_MASK : '0;
        analog_mask = analog_sel & ANALOG_CAPABLE;
        sel         = gpio_reg_e'(bus_addr);
    end

    gpio_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .wr_sel     (sel),
        .wr_data    (bus_wdata),
        .claim_mask (claim_mask),
        .dir_q      (dir_q),
        .latch_q    (latch_q)
    );

    gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .dir_q      (dir_q),
        .latch_q    (latch_q),
        .claim_mask (claim_mask),
        .periph_en  (periph_en),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    // Select read data; claimed bits read zero everywhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                REG_PINS:  bus_rdata = pins_sync & ~analog_mask & ~claim_mask;
                REG_DRIVE: bus_rdata = latch_q & ~claim_mask;
                REG_DIR:   bus_rdata = dir_q & ~claim_mask;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
// Assertion checker for gpio_port, attached by bind below.
// Assumes it sees the top's direction and latch registers.
module gpio_port_chk #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] OSC_MASK = 8'hC0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic             bus_rd,
    input logic [WIDTH-1:0] bus_rdata,
    input logic             osc_claim,
    input logic [WIDTH-1:0] periph_en,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] latch_q
);
    // R1
    dir_write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !osc_claim && periph_en == '0)
        |=> (osc_claim || periph_en != '0 || pin_oe == ~$past(bus_wdata)));

    // R3
    latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && !osc_claim) |=> (latch_q == $past(bus_wdata)));

    // R5
    claim_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_claim |-> ((pin_oe & OSC_MASK) == '0));

    // R6
    claim_latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_claim |=> ((latch_q & OSC_MASK) == '0));

    // R7
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dir_q == '1 && latch_q == '0));

    // R9
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .OSC_MASK(OSC_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .osc_claim (osc_claim),
    .periph_en (periph_en),
    .pin_oe    (pin_oe),
    .dir_q     (dir_q),
    .latch_q   (latch_q)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    typedef struct packed {
        logic [3:0] req;
        logic       wr;
        logic [1:0] waddr;
        logic [7:0] wdata;
        logic [7:0] pins;
        logic [7:0] ana;
        logic       osc;
        logic [1:0] raddr;
        logic [7:0] exp;
    } vec_t;

    // State carries from row to row; reset leaves dir FF, latch 00.
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b0, 2'd0, 8'h00, 8'hA5, 8'h00, 1'b0, 2'd0, 8'hA5}, // R2 pins
        '{4'd4, 1'b0, 2'd0, 8'h00, 8'hFF, 8'h2F, 1'b0, 2'd0, 8'hD0}, // R4 analog
        '{4'd4, 1'b0, 2'd0, 8'h00, 8'hFF, 8'hFF, 1'b0, 2'd0, 8'hD0}, // R4 mask
        '{4'd3, 1'b1, 2'd1, 8'h3C, 8'h00, 8'h00, 1'b0, 2'd1, 8'h3C}, // R3 latch
        '{4'd3, 1'b1, 2'd0, 8'h5A, 8'h00, 8'h00, 1'b0, 2'd1, 8'h5A}, // R3 via 0
        '{4'd9, 1'b1, 2'd2, 8'hCF, 8'h00, 8'h00, 1'b0, 2'd2, 8'hCF}, // R9 dir
        '{4'd5, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 1'b1, 2'd2, 8'h0F}, // R5 dir
        '{4'd6, 1'b1, 2'd1, 8'hFF, 8'h00, 8'h00, 1'b1, 2'd1, 8'h3F}, // R6 write
        '{4'd6, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 2'd1, 8'h3F}, // R6 release
        '{4'd5, 1'b0, 2'd0, 8'h00, 8'hFF, 8'h00, 1'b1, 2'd0, 8'h3F}, // R5 pins
        '{4'd2, 1'b0, 2'd0, 8'h00, 8'hFF, 8'h00, 1'b0, 2'd0, 8'hFF}  // R2 pins
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] analog_sel = '0;
    logic       osc_claim = 1'b0;
    logic [7:0] periph_en = '0;
    logic [7:0] periph_out = '0;
    logic [7:0] periph_oe = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .analog_sel(analog_sel), .osc_claim(osc_claim),
        .periph_en(periph_en), .periph_out(periph_out), .periph_oe(periph_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        chk("R7 oe", pin_oe, 8'h00);
        rd(2'd1, d); chk("R7 latch", d, 8'h00);
        rd(2'd2, d); chk("R7 dir", d, 8'hFF);
        rd(2'd0, d); chk("R7 sync", d, 8'h00);

        foreach (VECS[i]) begin
            @(negedge clk);
            pin_in = VECS[i].pins; analog_sel = VECS[i].ana; osc_claim = VECS[i].osc;
            bus_wr = VECS[i].wr; bus_addr = VECS[i].waddr; bus_wdata = VECS[i].wdata;
            @(negedge clk);
            bus_wr = 1'b0;
            repeat (2) @(negedge clk);
            rd(VECS[i].raddr, d);
            chk($sformatf("R%0d table row %0d", VECS[i].req, i), d, VECS[i].exp);
        end

        // State: dir CF, latch 3F, osc 0, pins FF.
        analog_sel = '0;
        @(negedge clk);
        // R1 drive from latch where dir is 0
        chk("R1 oe", pin_oe, 8'h30);
        chk("R1 out", pin_out, 8'h3F);
        // R9 idle read and unused address
        bus_addr = 2'd1; #1 chk("R9 idle rdata", bus_rdata, 8'h00);
        rd(2'd3, d); chk("R9 addr3 read", d, 8'h00);
        wr(2'd3, 8'h00);
        rd(2'd1, d); chk("R9 addr3 write latch", d, 8'h3F);
        rd(2'd2, d); chk("R9 addr3 write dir", d, 8'hCF);
        // R1 all outputs after direction write
        wr(2'd2, 8'h00);
        chk("R1 oe all", pin_oe, 8'hFF);
        // R5 claim removes drive on top bits
        osc_claim = 1'b1;
        #1 chk("R5 oe", pin_oe, 8'h3F);
        periph_en = 8'h80; periph_oe = 8'h80; periph_out = 8'h80;
        #1 chk("R5 periph blocked", pin_oe, 8'h3F);
        @(negedge clk);
        osc_claim = 1'b0; periph_en = '0; periph_oe = '0; periph_out = '0;
        // R8 peripheral override on bit 0
        @(negedge clk);
        periph_en = 8'h01; periph_out = 8'h00; periph_oe = 8'h01;
        #1 chk("R8 out", pin_out, 8'h3E);
        periph_oe = 8'h00;
        #1 chk("R8 oe", pin_oe, 8'hFE);
        periph_en = '0;
        // R2 two-edge lag
        @(negedge clk);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'hA5;
        @(negedge clk);
        rd(2'd0, d); chk("R2 one edge", d, 8'h00);
        @(negedge clk);
        rd(2'd0, d); chk("R2 two edges", d, 8'hA5);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule